// File: doc/BRIEF.md
# Outstanding-Miss Tracker with Acknowledgement Counting

This block keeps a small, fully associative table of cache-line misses that are still in flight. Each slot records the line address, a transient coherence state code, a copy of the line's data word, a dirty bit, a prefetch bit and a signed count of acknowledgements still owed. The surrounding controller allocates a slot when it issues a miss, looks slots up by address, and frees them when the transaction retires.

For every incoming coherence response, the block classifies the response into an event for the controller. The inputs are the response kind, whether the sender is a peer first-level cache, the ack count carried by the message, the line address and the line's current state. A data or ack response is final when the stored count equals the message's ack count; otherwise it is partial. A partial response subtracts its ack count from the stored count. Acks and data may arrive in any order, so the count is signed and may go negative before the data announces the total.

Top module: `miss_ack_tracker`

## Requirements
- R1: After reset every slot is empty: a lookup of any address reports no hit.
- R2: An accepted allocation stores address, state, data and dirty bit into a slot, sets its pending count to 0 and clears its prefetch bit; from the next cycle a lookup returns exactly these values.
- R3: An allocation is rejected (alloc_err high in the same cycle) when every slot is valid or the address is already present, and a rejected allocation leaves the table unchanged.
- R4: Lookup is combinational and returns hit plus the slot index; an accepted allocation takes the lowest-numbered free slot.
- R5: Deallocation of a present address frees its slot at the next clock edge; deallocation of an absent address changes nothing.
- R6: A response of kind 1 (exclusive data) always yields event 3, whatever the state, sender or count.
- R7: A response of kind 0 (plain data) from a peer cache (rsp_from_l1 high) while rsp_line_state is 5 or 8 yields event 4; with another state or a non-peer sender it is classified by count.
- R8: For a data (kind 0) or ack (kind 2) response to a present address, the event is final (2 for data, 6 for ack) when stored count minus message ack count is zero, and partial (1 for data, 5 for ack) otherwise.
- R9: A partial response subtracts the message's signed ack count from the slot's count at the next edge, so the count can become negative.
- R10: Kind 3 (writeback acknowledge) yields event 7 with rsp_err low; any kind from 4 to 7, or a data/ack response that is not a peer-shared fill and whose address has no slot, raises rsp_err with event 0 and changes no count.
- R11: A final, exclusive or peer-shared data response leaves the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocation request |
| alloc_addr | input | AW | Line address to allocate |
| alloc_state | input | 4 | Transient state code to store |
| alloc_data | input | DW | Data word copied from the cache line |
| alloc_dirty | input | 1 | Dirty bit copied from the cache line |
| alloc_err | output | 1 | Allocation rejected (full or duplicate) |
| dealloc_vld | input | 1 | Deallocation request |
| dealloc_addr | input | AW | Line address to free |
| lk_addr | input | AW | Lookup address |
| lk_hit | output | 1 | Lookup found a valid slot |
| lk_idx | output | IW | Index of the matching slot |
| lk_state | output | 4 | Stored state of the matching slot |
| lk_data | output | DW | Stored data word |
| lk_dirty | output | 1 | Stored dirty bit |
| lk_pref | output | 1 | Stored prefetch bit |
| lk_pend | output | CW | Stored signed pending-ack count |
| rsp_vld | input | 1 | Response present |
| rsp_type | input | 3 | Response kind: 0 data, 1 exclusive data, 2 ack, 3 writeback ack |
| rsp_from_l1 | input | 1 | Sender is a peer first-level cache |
| rsp_line_state | input | 4 | Current line state (5 and 8 are the shared-fill waits) |
| rsp_acks | input | CW | Signed ack count carried by the response |
| rsp_addr | input | AW | Response line address |
| rsp_evt | output | 3 | Event: 0 none, 1 data partial, 2 data final, 3 exclusive data, 4 peer data, 5 ack partial, 6 ack final, 7 writeback done |
| rsp_err | output | 1 | Response cannot be classified |

## Verification
The bench builds the tracker with four slots, a 16-bit address, a 32-bit data word and a 6-bit signed count. Four slots make the full-table rejection reachable after a handful of allocations, and the reuse of a freed middle slot checks the lowest-free-slot order. The 6-bit count keeps ack-before-data sequences, where the count dips to -1 or -2 before returning to zero, well inside range.

// File: rtl/mt_pkg.sv
package mt_pkg;
   // response kinds
   localparam logic [2:0] RSP_DATA      = 3'd0;
   localparam logic [2:0] RSP_DATA_EXCL = 3'd1;
   localparam logic [2:0] RSP_ACK       = 3'd2;
   localparam logic [2:0] RSP_WB_ACK    = 3'd3;

   // line states that wait for a shared fill
   localparam logic [3:0] LS_WAIT_SH     = 4'd5;
   localparam logic [3:0] LS_WAIT_SH_INV = 4'd8;

   typedef enum logic [2:0] {
      EV_NONE      = 3'd0,
      EV_DATA_PART = 3'd1,
      EV_DATA_LAST = 3'd2,
      EV_DATA_EXCL = 3'd3,
      EV_DATA_PEER = 3'd4,
      EV_ACK_PART  = 3'd5,
      EV_ACK_LAST  = 3'd6,
      EV_WB_DONE   = 3'd7
   } evt_e;
endpackage

// File: rtl/mt_entry.sv
module mt_entry #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int CW = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 ld,
   input  logic [AW-1:0]        ld_addr,
   input  logic [3:0]           ld_state,
   input  logic [DW-1:0]        ld_data,
   input  logic                 ld_dirty,
   input  logic                 sub_en,
   input  logic signed [CW-1:0] sub_val,
   output logic                 valid,
   output logic [AW-1:0]        addr,
   output logic [3:0]           state,
   output logic [DW-1:0]        data,
   output logic                 dirty,
   output logic                 pref,
   output logic signed [CW-1:0] pend
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         state <= '0;
         data  <= '0;
         dirty <= 1'b0;
         pref  <= 1'b0;
         pend  <= '0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (ld) begin
         valid <= 1'b1;
         addr  <= ld_addr;
         state <= ld_state;
         data  <= ld_data;
         dirty <= ld_dirty;
         pref  <= 1'b0;
         pend  <= '0;
      end else if (sub_en) begin
         pend  <= pend - sub_val;
      end
   end

   // R2
   alloc_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr) |=> (valid && pend == '0 && !pref));
endmodule

// File: rtl/mt_match.sv
module mt_match #(
   parameter int AW        = 16,
   parameter int DEPTH     = 4,
   parameter bit OR_ENCODE = 1'b1,
   localparam int IW       = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]         vld,
   input  logic [DEPTH-1:0][AW-1:0] tags,
   input  logic [AW-1:0]            key,
   output logic                     hit,
   output logic [IW-1:0]            idx
);
   logic [DEPTH-1:0] hits;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         hits[i] = vld[i] && (tags[i] == key);
      end
   end

   assign hit = |hits;

   generate
      if (OR_ENCODE) begin : g_or
         always_comb begin
            idx = '0;
            for (int i = 0; i < DEPTH; i++) begin
               if (hits[i]) idx = idx | IW'(i);
            end
         end
      end else begin : g_pri
         always_comb begin
            idx = '0;
            for (int i = DEPTH - 1; i >= 0; i--) begin
               if (hits[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mt_classify.sv
module mt_classify
   import mt_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic [2:0]           kind,
   input  logic                 from_l1,
   input  logic [3:0]           line_state,
   input  logic signed [CW-1:0] acks,
   input  logic                 hit,
   input  logic signed [CW-1:0] pend,
   output evt_e                 evt,
   output logic                 err,
   output logic                 partial
);
   logic last;
   logic shared_wait;

   assign last        = (pend == acks);
   assign shared_wait = (line_state == LS_WAIT_SH) || (line_state == LS_WAIT_SH_INV);

   always_comb begin
      evt     = EV_NONE;
      err     = 1'b0;
      partial = 1'b0;
      case (kind)
         RSP_DATA_EXCL: evt = EV_DATA_EXCL;
         RSP_DATA: begin
            if (from_l1 && shared_wait) begin
               evt = EV_DATA_PEER;
            end else if (!hit) begin
               err = 1'b1;
            end else if (last) begin
               evt = EV_DATA_LAST;
            end else begin
               evt     = EV_DATA_PART;
               partial = 1'b1;
            end
         end
         RSP_ACK: begin
            if (!hit) begin
               err = 1'b1;
            end else if (last) begin
               evt = EV_ACK_LAST;
            end else begin
               evt     = EV_ACK_PART;
               partial = 1'b1;
            end
         end
         RSP_WB_ACK: evt = EV_WB_DONE;
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/miss_ack_tracker.sv
module miss_ack_tracker
   import mt_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int DEPTH     = 4,
   parameter int CW        = 6,
   parameter bit MATCH_OR  = 1'b1,
   localparam int IW       = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_vld,
   input  logic [AW-1:0]        alloc_addr,
   input  logic [3:0]           alloc_state,
   input  logic [DW-1:0]        alloc_data,
   input  logic                 alloc_dirty,
   output logic                 alloc_err,
   input  logic                 dealloc_vld,
   input  logic [AW-1:0]        dealloc_addr,
   input  logic [AW-1:0]        lk_addr,
   output logic                 lk_hit,
   output logic [IW-1:0]        lk_idx,
   output logic [3:0]           lk_state,
   output logic [DW-1:0]        lk_data,
   output logic                 lk_dirty,
   output logic                 lk_pref,
   output logic signed [CW-1:0] lk_pend,
   input  logic                 rsp_vld,
   input  logic [2:0]           rsp_type,
   input  logic                 rsp_from_l1,
   input  logic [3:0]           rsp_line_state,
   input  logic signed [CW-1:0] rsp_acks,
   input  logic [AW-1:0]        rsp_addr,
   output logic [2:0]           rsp_evt,
   output logic                 rsp_err
);
   localparam int NQ  = 4;
   localparam int QLK = 0;
   localparam int QRS = 1;
   localparam int QAL = 2;
   localparam int QDL = 3;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("miss_ack_tracker: DEPTH must be at least 2");
      end
      if (CW < 2) begin : g_bad_cw
         $error("miss_ack_tracker: CW must be at least 2");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("miss_ack_tracker: AW and DW must be positive");
      end
   endgenerate

   logic [DEPTH-1:0]           v;
   logic [DEPTH-1:0][AW-1:0]   tag;
   logic [3:0]                 st   [DEPTH];
   logic [DW-1:0]              dat  [DEPTH];
   logic                       drt  [DEPTH];
   logic                       prf  [DEPTH];
   logic signed [CW-1:0]       pnd  [DEPTH];

   logic [AW-1:0]              q_key [NQ];
   logic                       q_hit [NQ];
   logic [IW-1:0]              q_idx [NQ];

   assign q_key[QLK] = lk_addr;
   assign q_key[QRS] = rsp_addr;
   assign q_key[QAL] = alloc_addr;
   assign q_key[QDL] = dealloc_addr;

   generate
      for (genvar g = 0; g < NQ; g++) begin : g_port
         mt_match #(.AW(AW), .DEPTH(DEPTH), .OR_ENCODE(MATCH_OR)) u_match (
            .vld  (v),
            .tags (tag),
            .key  (q_key[g]),
            .hit  (q_hit[g]),
            .idx  (q_idx[g])
         );
      end
   endgenerate

   // lowest free slot
   logic          full;
   logic [IW-1:0] free_idx;
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!v[i]) free_idx = IW'(i);
      end
   end
   assign full      = &v;
   assign alloc_err = alloc_vld && (full || q_hit[QAL]);

   logic                 alloc_ok;
   logic                 dl_go;
   assign alloc_ok = alloc_vld && !alloc_err;
   assign dl_go    = dealloc_vld && q_hit[QDL];

   // response classification
   evt_e                 cls_evt;
   logic                 cls_err;
   logic                 cls_part;
   logic signed [CW-1:0] rs_pend;
   assign rs_pend = q_hit[QRS] ? pnd[q_idx[QRS]] : '0;

   mt_classify #(.CW(CW)) u_cls (
      .kind       (rsp_type),
      .from_l1    (rsp_from_l1),
      .line_state (rsp_line_state),
      .acks       (rsp_acks),
      .hit        (q_hit[QRS]),
      .pend       (rs_pend),
      .evt        (cls_evt),
      .err        (cls_err),
      .partial    (cls_part)
   );

   assign rsp_evt = rsp_vld ? cls_evt : EV_NONE;
   assign rsp_err = rsp_vld && cls_err;

   logic sub_go;
   assign sub_go = rsp_vld && cls_part && !cls_err;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         mt_entry #(.AW(AW), .DW(DW), .CW(CW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (dl_go && (q_idx[QDL] == IW'(i))),
            .ld       (alloc_ok && (free_idx == IW'(i))),
            .ld_addr  (alloc_addr),
            .ld_state (alloc_state),
            .ld_data  (alloc_data),
            .ld_dirty (alloc_dirty),
            .sub_en   (sub_go && (q_idx[QRS] == IW'(i))),
            .sub_val  (rsp_acks),
            .valid    (v[i]),
            .addr     (tag[i]),
            .state    (st[i]),
            .data     (dat[i]),
            .dirty    (drt[i]),
            .pref     (prf[i]),
            .pend     (pnd[i])
         );
      end
   endgenerate

   assign lk_hit   = q_hit[QLK];
   assign lk_idx   = q_idx[QLK];
   assign lk_state = lk_hit ? st[lk_idx]  : '0;
   assign lk_data  = lk_hit ? dat[lk_idx] : '0;
   assign lk_dirty = lk_hit && drt[lk_idx];
   assign lk_pref  = lk_hit && prf[lk_idx];
   assign lk_pend  = lk_hit ? pnd[lk_idx] : '0;

   // R3
   reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_vld && alloc_err && !dealloc_vld) |=> $stable(v));

   // R2
   alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ok && !dl_go) |=> ($countones(v) == $past($countones(v)) + 1));

   // R5
   dealloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dl_go |=> !v[$past(q_idx[QDL])]);

   // R9
   partial_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_go && !dl_go) |=>
         (pnd[$past(q_idx[QRS])] == CW'($past(rs_pend) - $past(rsp_acks))));

   // R11
   final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && q_hit[QRS] && !dl_go &&
       (rsp_evt == EV_DATA_LAST || rsp_evt == EV_ACK_LAST ||
        rsp_evt == EV_DATA_EXCL || rsp_evt == EV_DATA_PEER))
      |=> (pnd[$past(q_idx[QRS])] == $past(rs_pend)));
endmodule

// File: tb/sim_miss_ack_tracker.sv
module sim_miss_ack_tracker;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int CW = 6;
   localparam int IW = $clog2(DEPTH);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 alloc_vld = 1'b0;
   logic [AW-1:0]        alloc_addr = '0;
   logic [3:0]           alloc_state = '0;
   logic [DW-1:0]        alloc_data = '0;
   logic                 alloc_dirty = 1'b0;
   logic                 alloc_err;
   logic                 dealloc_vld = 1'b0;
   logic [AW-1:0]        dealloc_addr = '0;
   logic [AW-1:0]        lk_addr = '0;
   logic                 lk_hit;
   logic [IW-1:0]        lk_idx;
   logic [3:0]           lk_state;
   logic [DW-1:0]        lk_data;
   logic                 lk_dirty;
   logic                 lk_pref;
   logic signed [CW-1:0] lk_pend;
   logic                 rsp_vld = 1'b0;
   logic [2:0]           rsp_type = '0;
   logic                 rsp_from_l1 = 1'b0;
   logic [3:0]           rsp_line_state = '0;
   logic signed [CW-1:0] rsp_acks = '0;
   logic [AW-1:0]        rsp_addr = '0;
   logic [2:0]           rsp_evt;
   logic                 rsp_err;

   always #10 clk = ~clk;

   miss_ack_tracker #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u0 (.*);

   typedef struct {
      string  tag;
      longint got;
      longint exp;
   } item_t;

   item_t sb[$];
   event  sb_ev;
   int    n_chk = 0;
   int    n_fail = 0;

   task automatic chk(string tag, longint got, longint exp);
      sb.push_back('{tag, got, exp});
      -> sb_ev;
   endtask

   task automatic drain();
      while (sb.size() > 0) begin
         item_t it = sb.pop_front();
         n_chk++;
         if (it.got != it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", it.tag, it.got, it.exp);
         end
      end
   endtask

   initial begin
      forever begin
         @(sb_ev);
         drain();
      end
   end

   task automatic finish_run();
      drain();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   task automatic do_alloc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic dty, input logic [3:0] s,
                           input logic exp_err, input string tag);
      @(negedge clk);
      alloc_vld = 1'b1; alloc_addr = a; alloc_data = d;
      alloc_dirty = dty; alloc_state = s;
      #2 chk({tag, " alloc_err"}, alloc_err, exp_err);
      @(posedge clk);
      #1 alloc_vld = 1'b0;
   endtask

   task automatic do_dealloc(input logic [AW-1:0] a);
      @(negedge clk);
      dealloc_vld = 1'b1; dealloc_addr = a;
      @(posedge clk);
      #1 dealloc_vld = 1'b0;
   endtask

   task automatic look(input logic [AW-1:0] a, input logic exp_hit,
                       input int exp_idx, input string tag);
      @(negedge clk);
      lk_addr = a;
      #2;
      chk({tag, " hit"}, lk_hit, exp_hit);
      if (exp_hit) chk({tag, " idx"}, lk_idx, exp_idx);
   endtask

   task automatic look_pend(input logic [AW-1:0] a, input int exp_pend, input string tag);
      @(negedge clk);
      lk_addr = a;
      #2 chk({tag, " pend"}, lk_pend, exp_pend);
   endtask

   task automatic resp(input logic [AW-1:0] a, input logic [2:0] k, input logic fl1,
                       input logic [3:0] ls, input int acks,
                       input int exp_evt, input logic exp_err, input string tag);
      @(negedge clk);
      rsp_vld = 1'b1; rsp_addr = a; rsp_type = k; rsp_from_l1 = fl1;
      rsp_line_state = ls; rsp_acks = CW'(acks);
      #2;
      chk({tag, " evt"}, rsp_evt, exp_evt);
      chk({tag, " err"}, rsp_err, exp_err);
      @(posedge clk);
      #1 rsp_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: empty after reset
      look(16'h0010, 1'b0, 0, "R1 reset 0x10");
      look(16'h0000, 1'b0, 0, "R1 reset 0x00");

      // R2: allocation contents
      do_alloc(16'h0010, 32'hAAAA0001, 1'b1, 4'd6, 1'b0, "R2 first");
      look(16'h0010, 1'b1, 0, "R2 lookup");
      chk("R2 state", lk_state, 6);
      chk("R2 data", lk_data, 32'hAAAA0001);
      chk("R2 dirty", lk_dirty, 1);
      chk("R2 pref", lk_pref, 0);
      chk("R2 pend", lk_pend, 0);

      // R3: duplicate rejected
      do_alloc(16'h0010, 32'h0, 1'b0, 4'd5, 1'b1, "R3 dup");
      look(16'h0010, 1'b1, 0, "R3 dup keeps");
      chk("R3 dup data kept", lk_data, 32'hAAAA0001);

      // R4: lowest free slots in order, then full rejection
      do_alloc(16'h0020, 32'h2, 1'b0, 4'd6, 1'b0, "R4 second");
      do_alloc(16'h0030, 32'h3, 1'b0, 4'd5, 1'b0, "R4 third");
      do_alloc(16'h0040, 32'h4, 1'b0, 4'd5, 1'b0, "R4 fourth");
      look(16'h0020, 1'b1, 1, "R4 0x20");
      look(16'h0030, 1'b1, 2, "R4 0x30");
      look(16'h0040, 1'b1, 3, "R4 0x40");
      do_alloc(16'h0050, 32'h5, 1'b0, 4'd6, 1'b1, "R3 full");
      look(16'h0050, 1'b0, 0, "R3 full no slot");

      // R8/R9: ack before data on 0x10
      resp(16'h0010, 3'd2, 1'b0, 4'd6, 1, 5, 1'b0, "R8 ack partial");
      look_pend(16'h0010, -1, "R9 negative");
      resp(16'h0010, 3'd0, 1'b0, 4'd6, -1, 2, 1'b0, "R8 data final");
      look_pend(16'h0010, -1, "R11 final hold");

      // R8/R9: data first then two acks on 0x20
      resp(16'h0020, 3'd0, 1'b0, 4'd6, 2, 1, 1'b0, "R8 data partial");
      look_pend(16'h0020, -2, "R9 after data");
      resp(16'h0020, 3'd2, 1'b0, 4'd6, -1, 5, 1'b0, "R8 ack partial 2");
      look_pend(16'h0020, -1, "R9 after ack");
      resp(16'h0020, 3'd2, 1'b0, 4'd6, -1, 6, 1'b0, "R8 ack final");
      look_pend(16'h0020, -1, "R11 ack final hold");

      // R6: exclusive data
      resp(16'h0030, 3'd1, 1'b1, 4'd5, 5, 3, 1'b0, "R6 excl");
      look_pend(16'h0030, 0, "R11 excl hold");
      resp(16'h0099, 3'd1, 1'b0, 4'd6, 0, 3, 1'b0, "R6 excl no slot");

      // R7: peer-shared data
      resp(16'h0040, 3'd0, 1'b1, 4'd5, 3, 4, 1'b0, "R7 peer wait");
      resp(16'h0040, 3'd0, 1'b1, 4'd8, 3, 4, 1'b0, "R7 peer wait-inv");
      look_pend(16'h0040, 0, "R11 peer hold");
      resp(16'h0040, 3'd0, 1'b1, 4'd6, 0, 2, 1'b0, "R7 peer other state");
      resp(16'h0040, 3'd0, 1'b0, 4'd5, 0, 2, 1'b0, "R7 non-peer");

      // R10: writeback ack and errors
      resp(16'h0077, 3'd3, 1'b0, 4'd9, 0, 7, 1'b0, "R10 wb");
      resp(16'h0010, 3'd5, 1'b0, 4'd6, 1, 0, 1'b1, "R10 bad kind");
      look_pend(16'h0010, -1, "R10 bad kind no change");
      resp(16'h0099, 3'd2, 1'b0, 4'd6, 1, 0, 1'b1, "R10 ack no slot");

      // R5: deallocation
      do_dealloc(16'h0020);
      look(16'h0020, 1'b0, 0, "R5 freed");
      do_dealloc(16'h0077);
      look(16'h0010, 1'b1, 0, "R5 absent no effect");
      look(16'h0040, 1'b1, 3, "R5 absent keeps 0x40");
      do_alloc(16'h0050, 32'h55, 1'b0, 4'd6, 1'b0, "R4 reuse");
      look(16'h0050, 1'b1, 1, "R4 reuse lowest");
      chk("R2 reuse pend", lk_pend, 0);

      repeat (2) @(posedge clk);
      finish_run();
   end
endmodule